// File: doc/BRIEF.md
# Polled Keyboard Input Port

This block is a small input peripheral that sits on a 16-bit memory bus. It answers two fixed addresses: a status word that tells software whether a keystroke is waiting, and a data word that holds the delivered character. Characters arrive on a byte stream with a valid/ready handshake. Software polls the status word; a poll never stalls the bus and always returns at once. Reads of any other address pass straight through from ordinary memory.

Reads are combinational within the bus access. Each access is therefore a single cycle: the block raises a hit flag for one of its own two addresses, and the bus mux uses that flag to pick the block's read data over the memory data. A status poll that finds a key waiting in the input buffer moves that key into the data word at the end of the same access. A later read of the data word returns the character and frees the block to accept the next key. Writes to either address have no effect.

Top module: `kbd_poll_port`

## Requirements
- R1: `kbd_hit` is high in the same cycle exactly when `bus_rd` is high and `bus_addr` is 0xFE00 (status) or 0xFE02 (data). Neighbouring addresses such as 0xFE01 and 0xFE03 do not hit, and nothing hits while `bus_rd` is low.
- R2: In every cycle without a hit, `rd_data` equals `mem_rdata` in that same cycle.
- R3: A status read in a cycle where a key is pending returns 0x8000 in that cycle, with only bit 15 set. A key is pending from the cycle after it is accepted on the input until the cycle after the data word is read following delivery.
- R4: A status read with no key pending returns 0x0000 in the same cycle. This includes the cycle in which a key is being offered and accepted.
- R5: A status read that finds an accepted key in the input buffer copies the key into the data word at the end of that access. The data word changes only in this way. A data read made before such a status read returns the previous data word.
- R6: A data read returns the stored character in bits 7:0, with bits 15:8 at zero.
- R7: `key_ready` is high only while no undelivered key is held. A key that is offered while `key_ready` is low is not taken, and the key already held is kept unchanged.
- R8: A data read of a delivered key clears the pending state. In the next cycle a status read returns 0x0000 and `key_ready` is high again.
- R9: Bus writes (`bus_wr`) to either address are ignored. They neither clear a pending key nor change the data word, and they do not raise `kbd_hit`.
- R10: Synchronous active-low reset empties the block. After reset `key_ready` is high, a status read returns 0x0000 and a data read returns 0x0000, even if a key was held before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | Input stream: a character is offered |
| key_data | input | 8 | Input stream: character code |
| key_ready | output | 1 | Input stream: block can accept a character |
| bus_rd | input | 1 | Bus read strobe for this cycle |
| bus_wr | input | 1 | Bus write strobe for this cycle (ignored by the block) |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data (ignored by the block) |
| mem_rdata | input | 16 | Read data from ordinary memory |
| rd_data | output | 16 | Muxed read data returned to the bus |
| kbd_hit | output | 1 | The current read targets one of this block's addresses |

## Verification
The read results (`rd_data`, `kbd_hit`) are due in the same cycle as the strobe and address. The state effects (key acceptance, the move into the data word, clearing on a data read, reset) show up one cycle later, at the following access or on `key_ready`. The bench drives each access on the falling edge and samples the outputs 1 ns later. A single-cycle read result is therefore checked against the state left by earlier edges. Any state change is checked by the next access in the sequence. Because of this, a check never samples in the cycle where a register is still being updated.

// File: rtl/kbd_poll_pkg.sv
// Package: shared constants and types for the polled keyboard port.
// Assumes a word-addressed 16-bit bus with single-cycle reads.
package kbd_poll_pkg;

    localparam int unsigned KP_ADDR_W    = 16;
    localparam int unsigned KP_DATA_W    = 16;
    localparam int unsigned KP_CHAR_W    = 8;
    localparam int unsigned KP_READY_BIT = 15;
    localparam logic [15:0] KP_STAT_ADDR = 16'hFE00;
    localparam logic [15:0] KP_DATA_ADDR = 16'hFE02;

    // Decoded kind of the current bus read
    typedef struct packed {
        logic stat_rd;
        logic data_rd;
    } kp_access_t;

endpackage

// File: rtl/kbd_poll_decode.sv
// Module: address decoder for the two port addresses.
// Only reads are decoded; writes never produce an access. Purely combinational.
module kbd_poll_decode
    import kbd_poll_pkg::*;
#(
    parameter int unsigned ADDR_W    = KP_ADDR_W,
    parameter logic [ADDR_W-1:0] STAT_ADDR = KP_STAT_ADDR[ADDR_W-1:0],
    parameter logic [ADDR_W-1:0] DATA_ADDR = KP_DATA_ADDR[ADDR_W-1:0]
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output kp_access_t        acc,
    output logic              hit
);

    // Classify the read by matching the address
    always_comb begin
        acc.stat_rd = bus_rd && (bus_addr == STAT_ADDR);
        acc.data_rd = bus_rd && (bus_addr == DATA_ADDR);
        hit         = acc.stat_rd || acc.data_rd;
    end

endmodule

// File: rtl/kbd_poll_capture.sv
// Module: one-entry input buffer behind the valid/ready handshake.
// Accepts a character only when neither this buffer nor the delivered
// data word holds an undelivered key. Emptied when a status poll takes it.
module kbd_poll_capture #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_data,
    input  logic              deliv_busy,
    input  logic              take,
    output logic              key_ready,
    output logic              hold_vld,
    output logic [CHAR_W-1:0] hold_char
);

    logic accept;

    // Ready only when no undelivered key exists anywhere in the block
    always_comb begin
        key_ready = !hold_vld && !deliv_busy;
        accept    = key_valid && key_ready;
    end

    // Buffer state: fill on accept, empty when the poll takes the key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_char <= '0;
        end else if (accept) begin
            hold_vld  <= 1'b1;
            hold_char <= key_data;
        end else if (take) begin
            hold_vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/kbd_poll_deliver.sv
// Module: data word and delivered flag.
// Loads the buffered key, zero-extended, on a status poll that finds it.
// Clears the delivered flag when the data word is read.
module kbd_poll_deliver #(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_char,
    input  logic              data_rd,
    output logic              deliv_vld,
    output logic [DATA_W-1:0] data_word
);

    localparam int unsigned PAD_W = DATA_W - CHAR_W;

    // Data word and flag: load on poll transfer, release on data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliv_vld <= 1'b0;
            data_word <= '0;
        end else if (load) begin
            deliv_vld <= 1'b1;
            data_word <= {{PAD_W{1'b0}}, load_char};
        end else if (data_rd) begin
            deliv_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/kbd_poll_port.sv
// Module: polled keyboard status/data port on a 16-bit memory bus (top).
// Reads are single-cycle and combinational: kbd_hit selects this block's
// data over mem_rdata. Bus writes are accepted on the bus but have no effect.
module kbd_poll_port
    import kbd_poll_pkg::*;
#(
    parameter int unsigned ADDR_W    = KP_ADDR_W,
    parameter int unsigned DATA_W    = KP_DATA_W,
    parameter int unsigned CHAR_W    = KP_CHAR_W,
    parameter int unsigned READY_BIT = KP_READY_BIT,
    parameter logic [ADDR_W-1:0] STAT_ADDR = KP_STAT_ADDR[ADDR_W-1:0],
    parameter logic [ADDR_W-1:0] DATA_ADDR = KP_DATA_ADDR[ADDR_W-1:0]
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_data,
    output logic              key_ready,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              kbd_hit
);

    kp_access_t        acc;
    logic              hold_vld;
    logic [CHAR_W-1:0] hold_char;
    logic              deliv_vld;
    logic [DATA_W-1:0] data_word;
    logic              take;
    logic              pending;
    logic [DATA_W-1:0] stat_word;
    logic              wr_unused;

    // Writes are deliberately ignored; fold them into a sink
    assign wr_unused = bus_wr ^ (^bus_wdata);

    kbd_poll_decode #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_decode (
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .acc      (acc),
        .hit      (kbd_hit)
    );

    // A poll that finds a buffered key moves it in the same access
    assign take = acc.stat_rd && hold_vld;

    kbd_poll_capture #(
        .CHAR_W (CHAR_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_valid  (key_valid),
        .key_data   (key_data),
        .deliv_busy (deliv_vld),
        .take       (take),
        .key_ready  (key_ready),
        .hold_vld   (hold_vld),
        .hold_char  (hold_char)
    );

    kbd_poll_deliver #(
        .CHAR_W (CHAR_W),
        .DATA_W (DATA_W)
    ) u_deliver (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_char (hold_char),
        .data_rd   (acc.data_rd),
        .deliv_vld (deliv_vld),
        .data_word (data_word)
    );

    // Status word: single ready flag at READY_BIT, all other bits zero
    always_comb begin
        pending              = hold_vld || deliv_vld;
        stat_word            = '0;
        stat_word[READY_BIT] = pending;
    end

    // Read mux: own registers on a hit, memory otherwise
    always_comb begin
        if (acc.stat_rd)      rd_data = stat_word;
        else if (acc.data_rd) rd_data = data_word;
        else                  rd_data = mem_rdata;
    end

endmodule

// File: rtl/kbd_poll_port_chk.sv
// Module: assertion checker for kbd_poll_port, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module kbd_poll_port_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CHAR_W    = 8,
    parameter int unsigned READY_BIT = 15,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE00,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE02
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              kbd_hit,
    input logic              key_valid,
    input logic              key_ready
);

    localparam logic [DATA_W-1:0] READY_MASK = DATA_W'(1) << READY_BIT;

    // R1: no hit without a read strobe
    p_hit_needs_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> !kbd_hit);

    // R2: foreign addresses pass memory data through
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != STAT_ADDR && bus_addr != DATA_ADDR)
        |-> (!kbd_hit && rd_data == mem_rdata));

    // R3/R4: a status read carries nothing outside the ready bit
    p_status_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_ADDR) |-> ((rd_data & ~READY_MASK) == '0));

    // R6: data reads are zero-extended
    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_ADDR) |-> (rd_data[DATA_W-1:CHAR_W] == '0));

    // R7: an accepted key blocks further keys in the next cycle
    p_one_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready) |=> !key_ready);

endmodule

bind kbd_poll_port kbd_poll_port_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CHAR_W    (CHAR_W),
    .READY_BIT (READY_BIT),
    .STAT_ADDR (STAT_ADDR),
    .DATA_ADDR (DATA_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data),
    .kbd_hit   (kbd_hit),
    .key_valid (key_valid),
    .key_ready (key_ready)
);

// File: tb/test_kbd_poll_port.sv
// Bench for kbd_poll_port: a vector table walked by one loop, then directed
// reset and corner tests. Inputs change on the falling edge; outputs are
// sampled 1 ns later.
module test_kbd_poll_port;

    localparam logic [15:0] ST = 16'hFE00;
    localparam logic [15:0] DT = 16'hFE02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [7:0]  key_data = '0;
    logic        key_ready;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] rd_data;
    logic        kbd_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    kbd_poll_port i_kbd_poll_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_data  (key_data),
        .key_ready (key_ready),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mem_rdata (mem_rdata),
        .rd_data   (rd_data),
        .kbd_hit   (kbd_hit)
    );

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        kv;
        logic [15:0] addr;
        logic [7:0]  kch;
        logic [15:0] mem;
        logic [15:0] exp_rd;
        logic        exp_hit;
        logic        exp_rdy;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'hA5A5, 16'h0000, 1'b1, 1'b1, 4'd4}, // R4 empty poll
        '{1'b1,1'b0,1'b0, 16'h1234, 8'h00, 16'hBEEF, 16'hBEEF, 1'b0, 1'b1, 4'd2}, // R2 pass-through
        '{1'b1,1'b0,1'b0, 16'hFE01, 8'h00, 16'h0F0F, 16'h0F0F, 1'b0, 1'b1, 4'd1}, // R1 neighbour
        '{1'b1,1'b0,1'b0, 16'hFE03, 8'h00, 16'h1111, 16'h1111, 1'b0, 1'b1, 4'd1}, // R1 neighbour
        '{1'b0,1'b0,1'b1, ST,       8'h41, 16'h2222, 16'h2222, 1'b0, 1'b1, 4'd7}, // R7 key taken
        '{1'b0,1'b0,1'b1, ST,       8'h42, 16'h3333, 16'h3333, 1'b0, 1'b0, 4'd7}, // R7 refused
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'h4444, 16'h8000, 1'b1, 1'b0, 4'd3}, // R3 poll moves 41
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'h4444, 16'h8000, 1'b1, 1'b0, 4'd3}, // R3 still pending
        '{1'b0,1'b1,1'b0, DT,       8'h00, 16'h5555, 16'h5555, 1'b0, 1'b0, 4'd9}, // R9 write ignored
        '{1'b1,1'b0,1'b0, DT,       8'h00, 16'h6666, 16'h0041, 1'b1, 1'b0, 4'd5}, // R5 first key kept
        '{1'b0,1'b0,1'b1, ST,       8'h42, 16'h7777, 16'h7777, 1'b0, 1'b1, 4'd8}, // R8 ready again
        '{1'b1,1'b0,1'b0, DT,       8'h00, 16'h6666, 16'h0041, 1'b1, 1'b0, 4'd5}, // R5 no poll yet
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'h4444, 16'h8000, 1'b1, 1'b0, 4'd3}, // R3 moves 42
        '{1'b0,1'b1,1'b0, ST,       8'h00, 16'h5555, 16'h5555, 1'b0, 1'b0, 4'd9}, // R9 write status
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'h4444, 16'h8000, 1'b1, 1'b0, 4'd9}, // R9 not cleared
        '{1'b1,1'b0,1'b0, DT,       8'h00, 16'h6666, 16'h0042, 1'b1, 1'b0, 4'd9}, // R9 data intact
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'h4444, 16'h0000, 1'b1, 1'b1, 4'd8}, // R8 cleared
        '{1'b0,1'b0,1'b1, ST,       8'hFF, 16'h1357, 16'h1357, 1'b0, 1'b1, 4'd7}, // R7 take FF
        '{1'b1,1'b0,1'b0, ST,       8'h00, 16'h4444, 16'h8000, 1'b1, 1'b0, 4'd3}, // R3 moves FF
        '{1'b1,1'b0,1'b0, DT,       8'h00, 16'h6666, 16'h00FF, 1'b1, 1'b0, 4'd6}  // R6 zero-extend
    };

    // Drive one access at the falling edge and check the same-cycle outputs
    task automatic access(input logic rd, input logic wr, input logic kv,
                          input logic [15:0] addr, input logic [7:0] kch,
                          input logic [15:0] mem, input logic [15:0] exp_rd,
                          input logic exp_hit, input logic exp_rdy,
                          input int req);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; key_valid = kv; bus_addr = addr;
        key_data = kch; mem_rdata = mem; bus_wdata = 16'hFFFF;
        #1;
        checks++;
        if (rd_data !== exp_rd || kbd_hit !== exp_hit || key_ready !== exp_rdy) begin
            errors++;
            $display("FAIL R%0d: rd_data=%h hit=%b ready=%b expected rd_data=%h hit=%b ready=%b",
                     req, rd_data, kbd_hit, key_ready, exp_rd, exp_hit, exp_rdy);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; key_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: state straight after reset
        access(1'b0,1'b0,1'b0, ST, 8'h00, 16'h9999, 16'h9999, 1'b0, 1'b1, 10);
        access(1'b1,1'b0,1'b0, DT, 8'h00, 16'h9999, 16'h0000, 1'b1, 1'b1, 10);

        for (int i = 0; i < NV; i++)
            access(VECS[i].rd, VECS[i].wr, VECS[i].kv, VECS[i].addr, VECS[i].kch,
                   VECS[i].mem, VECS[i].exp_rd, VECS[i].exp_hit, VECS[i].exp_rdy,
                   int'(VECS[i].req));

        // R4: a poll in the very cycle a key is accepted still reads empty
        access(1'b1,1'b0,1'b1, ST, 8'h7E, 16'h0000, 16'h0000, 1'b1, 1'b1, 4);
        access(1'b1,1'b0,1'b0, ST, 8'h00, 16'h0000, 16'h8000, 1'b1, 1'b0, 3);

        // R10: reset while a delivered key is held
        @(negedge clk);
        bus_rd = 1'b0; key_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        access(1'b1,1'b0,1'b0, ST, 8'h00, 16'h0000, 16'h0000, 1'b1, 1'b1, 10);
        access(1'b1,1'b0,1'b0, DT, 8'h00, 16'h0000, 16'h0000, 1'b1, 1'b1, 10);
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule